// File: doc/BRIEF.md
# Serial DDS Command Sweep Controller

This block drives a direct digital synthesizer that is programmed through a three-wire serial port: a serial clock that idles low, a data line, and an active-high update strobe that makes a freshly shifted command take effect. After the block leaves reset it first gives the synthesizer a reset pulse of fixed length. From then on, for as long as `enable` is held high, it sends one 40-bit command after another.

Each command carries a 32-bit tuning word in its low bits and zeros in the eight bits above (two control bits, the power-down bit and a five-bit phase offset). Bits go out least significant first. A built-in sweeper moves the tuning word in a triangle pattern. It starts at the lower bound, climbs by a fixed step to the upper bound, descends back, and repeats, never going past either bound. The bounds and the step are live inputs. A typical setting runs from 0x147AE148 to 0x28F5C28F in steps of 0x346DC6, which with a 125 MHz reference gives 10 MHz to 20 MHz in 100 kHz increments.

The serial clock is divided from the system clock. The strobe width and the reset width are parameters counted in system clocks.

Top module: `dds_sweep_ctrl`

## Requirements
- R1: While `rst_n` is low, `ser_clk`, `ser_data`, `upd_strobe`, `synth_rst` and `word_done` are all low.
- R2: After `rst_n` is released, `synth_rst` goes high for exactly `RST_CLKS` system clocks. No serial clock edge and no strobe occur before this pulse has ended.
- R3: `ser_clk` is low whenever no word is being shifted. Each bit takes `HALF_CLKS` clocks low followed by `HALF_CLKS` clocks high, and `ser_data` does not change while `ser_clk` is high.
- R4: Each command is 40 bits, sent least significant bit first. Bits 31..0 carry the tuning word. Bits 33..32 (control), bit 34 (power-down) and bits 39..35 (phase) are zero.
- R5: Exactly 40 rising `ser_clk` edges occur between successive strobes. `upd_strobe` is then high for `UPD_CLKS` clocks, and it is never high while `ser_clk` is high.
- R6: While the block is idle, holding `enable` low keeps `ser_clk` and `upd_strobe` low. Dropping `enable` in the middle of a word lets that word finish, including its strobe, and then no further word is sent.
- R7: The first word after `enable` rises from idle carries `sweep_lo`, and the sweep then heads upward.
- R8: While the sweep heads up, the next word is tw+step if that is no greater than `sweep_hi` (reaching the bound exactly is allowed). Otherwise the direction turns down and the next word is tw-step if that is no less than `sweep_lo`, else `sweep_lo`. The arithmetic is carried without 32-bit wrap.
- R9: While the sweep heads down, the next word is tw-step if that is no less than `sweep_lo`. Otherwise the direction turns up and the next word is tw+step if that is no greater than `sweep_hi`, else `sweep_hi`.
- R10: `word_done` is a single-cycle pulse, once per word, on the final cycle of that word's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the sweep while high |
| sweep_lo | input | 32 | Lower tuning-word bound |
| sweep_hi | input | 32 | Upper tuning-word bound (not below `sweep_lo`) |
| sweep_step | input | 32 | Tuning-word increment |
| ser_clk | output | 1 | Serial clock to the synthesizer, idles low |
| ser_data | output | 1 | Serial data, least significant bit first |
| upd_strobe | output | 1 | Active-high frequency update strobe |
| synth_rst | output | 1 | Active-high synthesizer reset pulse |
| word_done | output | 1 | One-cycle pulse per transmitted command |

## Verification
The hardest situations to reach are the turn-arounds. These include a bound hit exactly, a range that is not a multiple of the step, a step wider than the whole range, and bounds near the top of the 32-bit space where tw+step would wrap. Each needs its own sweep session with chosen bounds, and a passive serial receiver decodes every word and compares it with an arithmetic model of the triangle. A mid-word loss of `enable` is reached by counting received rising serial-clock edges and dropping `enable` at bit 12 of a word.

// File: rtl/dds_sweep_pkg.sv
// Shared widths, command layout and sequencer states for the DDS sweep controller.
// Assumes the synthesizer decodes the 40-bit word as tuning word in bits 31..0,
// control in 33..32, power-down in 34 and phase in 39..35.
package dds_sweep_pkg;
    localparam int TW_W  = 32;
    localparam int CTL_W = 2;
    localparam int PH_W  = 5;
    localparam int CMD_W = TW_W + CTL_W + 1 + PH_W;

    typedef logic [TW_W-1:0]  tw_t;
    typedef logic [CMD_W-1:0] cmd_t;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_SYNRST,
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_SHIFT,
        SQ_STROBE
    } sq_state_t;

    // Assemble one command word from its fields; control bits are always zero.
    function automatic cmd_t pack_cmd(tw_t tw, logic [PH_W-1:0] phase, logic pwr_dn);
        return {phase, pwr_dn, {CTL_W{1'b0}}, tw};
    endfunction
endpackage

// File: rtl/dds_pulse_timer.sv
// One-shot pulse of LEN clocks started by `fire`.
// Assumes LEN >= 1; a fire while the pulse is running is ignored.
module dds_pulse_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active,
    output logic last
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Down-counter holding the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (fire && cnt == '0)
            cnt <= CW'(LEN);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign active = (cnt != '0);
    assign last   = (cnt == CW'(1));
endmodule

// File: rtl/dds_bit_shifter.sv
// Shifts a command word out LSB first with an idle-low serial clock.
// Each bit: HALF clocks with clock low, then HALF clocks high; data changes
// only on the falling transition. Assumes `load` arrives only when not busy.
module dds_bit_shifter #(
    parameter int unsigned HALF = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  dds_sweep_pkg::cmd_t        cmd,
    output logic                       sclk,
    output logic                       sdata,
    output logic                       busy
);
    import dds_sweep_pkg::*;

    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BCW = $clog2(CMD_W + 1);

    cmd_t           sreg;
    logic [BCW-1:0] bits_left;
    logic [HCW-1:0] hcnt;
    logic           sclk_q;

    // Half-period timing, clock phase and bit advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg      <= '0;
            bits_left <= '0;
            hcnt      <= '0;
            sclk_q    <= 1'b0;
        end else if (load) begin
            sreg      <= cmd;
            bits_left <= BCW'(CMD_W);
            hcnt      <= HCW'(HALF - 1);
            sclk_q    <= 1'b0;
        end else if (bits_left != '0) begin
            if (hcnt != '0) begin
                hcnt <= hcnt - HCW'(1);
            end else begin
                hcnt <= HCW'(HALF - 1);
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q    <= 1'b0;
                    sreg      <= {1'b0, sreg[CMD_W-1:1]};
                    bits_left <= bits_left - BCW'(1);
                end
            end
        end
    end

    assign busy  = (bits_left != '0);
    assign sclk  = sclk_q;
    assign sdata = busy & sreg[0];
endmodule

// File: rtl/dds_tw_sweeper.sv
// Triangle sweep of the tuning word between two bounds.
// `reload` restarts at the lower bound heading up; `advance` takes one step.
// Arithmetic is one bit wider than the word so no sum wraps.
// Assumes lo <= hi.
module dds_tw_sweeper (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reload,
    input  logic                 advance,
    input  dds_sweep_pkg::tw_t   lo,
    input  dds_sweep_pkg::tw_t   hi,
    input  dds_sweep_pkg::tw_t   step,
    output dds_sweep_pkg::tw_t   tw
);
    import dds_sweep_pkg::*;

    tw_t         tw_q;
    logic        heading_up;
    logic [TW_W:0] up_sum;
    logic [TW_W:0] lo_plus;
    logic        can_up;
    logic        can_dn;
    tw_t         tw_nx;
    logic        dir_nx;

    // Candidate moves and whether each stays inside the bounds.
    always_comb begin
        up_sum  = {1'b0, tw_q} + {1'b0, step};
        lo_plus = {1'b0, lo} + {1'b0, step};
        can_up  = (up_sum <= {1'b0, hi});
        can_dn  = ({1'b0, tw_q} >= lo_plus);
        tw_nx   = tw_q;
        dir_nx  = heading_up;
        if (heading_up) begin
            if (can_up) begin
                tw_nx = up_sum[TW_W-1:0];
            end else begin
                dir_nx = 1'b0;
                tw_nx  = can_dn ? (tw_q - step) : lo;
            end
        end else begin
            if (can_dn) begin
                tw_nx = tw_q - step;
            end else begin
                dir_nx = 1'b1;
                tw_nx  = can_up ? up_sum[TW_W-1:0] : hi;
            end
        end
    end

    // Sweep position and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tw_q       <= '0;
            heading_up <= 1'b1;
        end else if (reload) begin
            tw_q       <= lo;
            heading_up <= 1'b1;
        end else if (advance) begin
            tw_q       <= tw_nx;
            heading_up <= dir_nx;
        end
    end

    assign tw = tw_q;
endmodule

// File: rtl/dds_sweep_ctrl.sv
// Host-side controller for a serially programmed DDS: resets the synthesizer
// once, then while enabled sends swept 40-bit commands each closed by an
// update strobe. Assumes sweep_lo <= sweep_hi; bounds are read live.
module dds_sweep_ctrl #(
    parameter int unsigned HALF_CLKS = 2,
    parameter int unsigned UPD_CLKS  = 4,
    parameter int unsigned RST_CLKS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic [31:0] sweep_lo,
    input  logic [31:0] sweep_hi,
    input  logic [31:0] sweep_step,
    output logic        ser_clk,
    output logic        ser_data,
    output logic        upd_strobe,
    output logic        synth_rst,
    output logic        word_done
);
    import dds_sweep_pkg::*;

    sq_state_t state, state_nx;
    logic      rst_fire, rst_last;
    logic      upd_fire, upd_last;
    logic      sh_load, sh_busy;
    logic      sw_reload, sw_adv;
    tw_t       cur_tw;

    dds_pulse_timer #(.LEN(RST_CLKS)) u_rst_pulse (
        .clk(clk), .rst_n(rst_n), .fire(rst_fire),
        .active(synth_rst), .last(rst_last)
    );

    dds_pulse_timer #(.LEN(UPD_CLKS)) u_upd_pulse (
        .clk(clk), .rst_n(rst_n), .fire(upd_fire),
        .active(upd_strobe), .last(upd_last)
    );

    dds_tw_sweeper u_sweep (
        .clk(clk), .rst_n(rst_n), .reload(sw_reload), .advance(sw_adv),
        .lo(sweep_lo), .hi(sweep_hi), .step(sweep_step), .tw(cur_tw)
    );

    dds_bit_shifter #(.HALF(HALF_CLKS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load),
        .cmd(pack_cmd(cur_tw, '0, 1'b0)),
        .sclk(ser_clk), .sdata(ser_data), .busy(sh_busy)
    );

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SQ_BOOT;
        else
            state <= state_nx;
    end

    // Sequencer transitions and per-state strobes to the sub-blocks.
    always_comb begin
        state_nx  = state;
        rst_fire  = 1'b0;
        upd_fire  = 1'b0;
        sh_load   = 1'b0;
        sw_reload = 1'b0;
        sw_adv    = 1'b0;
        case (state)
            SQ_BOOT: begin
                rst_fire = 1'b1;
                state_nx = SQ_SYNRST;
            end
            SQ_SYNRST: begin
                if (rst_last) state_nx = SQ_IDLE;
            end
            SQ_IDLE: begin
                sw_reload = 1'b1;
                if (enable) state_nx = SQ_LAUNCH;
            end
            SQ_LAUNCH: begin
                sh_load  = 1'b1;
                state_nx = SQ_SHIFT;
            end
            SQ_SHIFT: begin
                if (!sh_busy) begin
                    upd_fire = 1'b1;
                    state_nx = SQ_STROBE;
                end
            end
            SQ_STROBE: begin
                if (upd_last) begin
                    sw_adv   = 1'b1;
                    state_nx = enable ? SQ_LAUNCH : SQ_IDLE;
                end
            end
            default: state_nx = SQ_BOOT;
        endcase
    end

    assign word_done = (state == SQ_STROBE) && upd_last;
endmodule

// File: rtl/dds_sweep_chk.sv
// Protocol checker bound into dds_sweep_ctrl; observes ports and shifter activity.
module dds_sweep_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_clk,
    input logic ser_data,
    input logic upd_strobe,
    input logic synth_rst,
    input logic word_done,
    input logic sh_busy
);
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_busy |-> !ser_clk);

    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    p_strobe_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> (!sh_busy && !ser_clk));

    p_reset_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        synth_rst |-> (!sh_busy && !upd_strobe));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

    p_done_in_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> upd_strobe);

    p_done_ends_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !upd_strobe);
endmodule

bind dds_sweep_ctrl dds_sweep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .upd_strobe(upd_strobe), .synth_rst(synth_rst), .word_done(word_done),
    .sh_busy(sh_busy)
);

// File: tb/test_dds_sweep_ctrl.sv
module test_dds_sweep_ctrl;
    localparam int HALF = 2;
    localparam int UPD  = 4;
    localparam int RSTW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] sweep_lo = '0, sweep_hi = '0, sweep_step = '0;
    logic        ser_clk, ser_data, upd_strobe, synth_rst, word_done;

    always #2 clk = ~clk;

    dds_sweep_ctrl #(.HALF_CLKS(HALF), .UPD_CLKS(UPD), .RST_CLKS(RSTW)) i_dds_sweep_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sweep_lo(sweep_lo), .sweep_hi(sweep_hi), .sweep_step(sweep_step),
        .ser_clk(ser_clk), .ser_data(ser_data), .upd_strobe(upd_strobe),
        .synth_rst(synth_rst), .word_done(word_done)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sweep model
    longint m_lo, m_hi, m_st, m_tw;
    bit     m_up, m_first;
    string  m_tag;

    task automatic model_step();
        longint up_v;
        bit     dn_ok;
        up_v  = m_tw + m_st;
        dn_ok = (m_tw >= m_lo + m_st);
        m_tag = m_up ? "R8" : "R9";
        if (m_up) begin
            if (up_v <= m_hi) m_tw = up_v;
            else begin m_up = 0; m_tw = dn_ok ? m_tw - m_st : m_lo; end
        end else begin
            if (dn_ok) m_tw = m_tw - m_st;
            else begin m_up = 1; m_tw = (up_v <= m_hi) ? up_v : m_hi; end
        end
    endtask

    // Serial receiver state
    bit          p_sclk = 0, p_fq = 0, p_rst = 0, p_data = 0;
    int          hi_run = 0, lo_run = 0, fq_run = 0, rst_run = 0;
    int          bitcnt = 0, sclk_rises = 0, n_words = 0, n_done = 0, n_rstp = 0;
    logic [39:0] shreg = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !p_sclk) begin
                if (bitcnt > 0) chk(lo_run == HALF, "R3", lo_run, HALF);
                chk(!synth_rst, "R2", synth_rst, 0);
                shreg = {ser_data, shreg[39:1]};
                bitcnt++;
                sclk_rises++;
                hi_run = 1;
            end else if (ser_clk) begin
                hi_run++;
                if (ser_data !== p_data) chk(0, "R3", ser_data, p_data);
            end
            if (!ser_clk && p_sclk) begin
                chk(hi_run == HALF, "R3", hi_run, HALF);
                lo_run = 1;
            end else if (!ser_clk) lo_run++;

            if (upd_strobe && ser_clk) chk(0, "R5", 1, 0);
            if (upd_strobe && !p_fq) begin
                chk(!synth_rst && n_rstp == 1, "R2", n_rstp, 1);
                chk(bitcnt == 40, "R5", bitcnt, 40);
                chk(shreg[39:32] == 8'h00, "R4", shreg[39:32], 0);
                chk(longint'(shreg[31:0]) == m_tw, m_first ? "R7" : m_tag, shreg[31:0], m_tw);
                m_first = 0;
                model_step();
                bitcnt = 0;
                n_words++;
                fq_run = 1;
            end else if (upd_strobe) fq_run++;
            if (!upd_strobe && p_fq) begin
                chk(fq_run == UPD, "R5", fq_run, UPD);
                chk(n_done == n_words, "R10", n_done, n_words);
            end
            if (word_done) begin
                n_done++;
                chk(upd_strobe && fq_run == UPD, "R10", fq_run, UPD);
            end

            if (synth_rst && !p_rst) begin rst_run = 1; n_rstp++; end
            else if (synth_rst) rst_run++;
            if (!synth_rst && p_rst) begin
                chk(rst_run == RSTW, "R2", rst_run, RSTW);
                chk(sclk_rises == 0 && n_words == 0, "R2", sclk_rises, 0);
            end
            p_sclk = ser_clk; p_fq = upd_strobe; p_rst = synth_rst; p_data = ser_data;
        end
    end

    task automatic session(input longint lo, input longint hi, input longint st, input int n);
        int base;
        @(negedge clk);
        sweep_lo = lo[31:0]; sweep_hi = hi[31:0]; sweep_step = st[31:0];
        m_lo = lo; m_hi = hi; m_st = st; m_tw = lo; m_up = 1; m_first = 1;
        base = n_words;
        enable = 1;
        wait (n_words >= base + n);
        @(negedge clk);
        enable = 0;
        repeat (400) @(negedge clk);
    endtask

    initial begin
        int w0, r0;
        repeat (3) @(negedge clk);
        chk({ser_clk, ser_data, upd_strobe, synth_rst, word_done} == 5'b0, "R1",
            {ser_clk, ser_data, upd_strobe, synth_rst, word_done}, 0);
        rst_n = 1;
        repeat (100) @(negedge clk);
        chk(n_rstp == 1 && !synth_rst, "R2", n_rstp, 1);
        chk(sclk_rises == 0 && n_words == 0 && !upd_strobe && !ser_clk, "R6", sclk_rises, 0);

        session(100, 130, 7, 20);
        session(0, 20, 5, 20);
        session(10, 12, 5, 8);
        session(64'hFFFFFFF0, 64'hFFFFFFFF, 6, 10);
        session(64'h147AE148, 64'h28F5C28F, 64'h346DC6, 210);

        // R6: drop enable in the middle of a word
        @(negedge clk);
        sweep_lo = 1000; sweep_hi = 2000; sweep_step = 300;
        m_lo = 1000; m_hi = 2000; m_st = 300; m_tw = 1000; m_up = 1; m_first = 1;
        w0 = n_words;
        enable = 1;
        wait (n_words == w0 + 2);
        wait (bitcnt == 12);
        @(negedge clk);
        enable = 0;
        w0 = n_words;
        repeat (500) @(negedge clk);
        chk(n_words == w0 + 1, "R6", n_words, w0 + 1);
        r0 = sclk_rises;
        repeat (200) @(negedge clk);
        chk(sclk_rises == r0 && !upd_strobe, "R6", sclk_rises, r0);
        chk(n_done == n_words, "R10", n_done, n_words);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule